// File: doc/BRIEF.md
# Traceback Survivor Memory with Rotating Banks

This block sits behind the add-compare-select stage of a hard-decision Viterbi decoder. Every trellis step it takes one decision vector (one bit per state, naming which of the two predecessors won) together with the index of the state whose path metric is currently best. It keeps these vectors in three survivor banks. Each bank is a grid with one row per state and one column per trellis step, and has 5K columns. At any moment one bank is being filled, one is being walked backwards to find a reliable starting state, and one is being walked backwards to produce decoded bits. Each time the write bank fills, the three banks change roles.

The backward walks are done by one engine, the state machine `svm_walker`. Its states are IDLE, TRACE and DECODE. A rotation moves it from IDLE to TRACE (transition *launch*), where it spends one cycle per column from the newest column to the oldest. At the oldest column it goes to DECODE (transition *hand-over*) if a decodable bank exists, and otherwise back to IDLE (transition *warm-up end*). In DECODE it walks the decode bank the same way, emitting one bit per column, and then returns to IDLE (transition *finish*). If a rotation arrives on the last DECODE step, it goes straight to TRACE (transition *back-to-back*). The decoded bits come out newest first. They are pushed onto one of two stacks and popped, in forward time order, one bit per accepted input in the following period.

With the default K = 3 there are four states and 15 columns per bank. The first decoded bit appears 45 accepted inputs after reset.

Top module: `trellis_survivor_mem`

## Requirements
- R1: After reset `bit_valid` is low. No decoded bit is produced for the first 45 accepted inputs. The input with index 45 (counting from 0 after reset) is the first to yield one.
- R2: Each vector accepted with `dec_valid` is stored in the current write bank. It goes into the column given by the count of accepted inputs modulo 15, starting at column 0. Bit s of `dec_vec` is the decision bit of state s.
- R3: The 15th write into a bank triggers a rotation. The write bank becomes the traceback bank, the traceback bank becomes the decode bank, and the decode bank becomes the write bank.
- R4: Traceback of a bank starts in the state given on `best_state` together with that bank's 15th input. It walks columns 14 down to 0. The state it reaches after column 0 is the starting state for decoding the bank written just before it.
- R5: One step back from state s in a column whose decision bit for s is d leads to the state formed by shifting s left by one, dropping its top bit, and placing d in bit 0.
- R6: The decoded bit for a column is the most significant bit of the state occupied in that column. The decode bank is walked from column 14 to column 0.
- R7: Once primed, `bit_valid` pulses in the cycle after each accepted input. `bit_out` then carries the information bit of the input accepted 45 inputs earlier, so the bits leave in forward time order.
- R8: After a rotation the walker needs 15 cycles for traceback and 15 for decode, and it is ready for the next rotation 30 cycles later. Accepted inputs must therefore be at least two cycles apart.
- R9: `bit_valid` is never high in a cycle that does not follow an accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decision vector is offered this cycle |
| dec_vec | input | 4 | Decision bit per state (bit s for state s) |
| best_state | input | 2 | Index of the state with the best path metric after this step |
| bit_valid | output | 1 | `bit_out` holds a decoded bit this cycle |
| bit_out | output | 1 | Decoded information bit, forward time order |

## Verification
The riskiest coincidence is a rotation that lands on the same edge as the walker's final decode step. On that edge the last bit is pushed onto one stack, the stacks swap, the last pending bit is popped from the other stack, and a new traceback starts from a fresh best state. The bench provokes this by sending inputs every second cycle, which puts each rotation exactly 30 cycles after the previous one. It judges the result by checking every decoded bit against the information stream that drove its own encoder model. Longer and mixed gaps are used as a contrast, so that the walker sits idle before some rotations.

// File: rtl/svm_pkg.sv
package svm_pkg;

    localparam int NUM_BANKS = 3;

    typedef enum logic [1:0] {
        WK_IDLE   = 2'd0,
        WK_TRACE  = 2'd1,
        WK_DECODE = 2'd2
    } walk_e;

endpackage

// File: rtl/svm_banks.sv
module svm_banks #(
    parameter int NS    = 4,
    parameter int STEPS = 15,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [1:0]    wr_bank,
    input  logic [CW-1:0] wr_col,
    input  logic [NS-1:0] wr_vec,
    input  logic [1:0]    rd_bank,
    input  logic [CW-1:0] rd_col,
    output logic [NS-1:0] rd_vec
);
    import svm_pkg::*;

    logic [NS-1:0] bank_rd [NUM_BANKS];

    // one column store per bank; each column is the decision vector of one step
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [NS-1:0] cols [STEPS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 2'(b))) begin
                cols[wr_col] <= wr_vec;
            end
        end

        assign bank_rd[b] = cols[rd_col];
    end

    always_comb begin
        unique case (rd_bank)
            2'd0:    rd_vec = bank_rd[0];
            2'd1:    rd_vec = bank_rd[1];
            default: rd_vec = bank_rd[2];
        endcase
    end

endmodule

// File: rtl/svm_walker.sv
module svm_walker #(
    parameter int M     = 2,
    parameter int STEPS = 15,
    parameter int CW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                dec_en,
    input  logic [M-1:0]        start_state,
    input  logic [(1<<M)-1:0]   rd_vec,
    output logic [CW-1:0]       rd_col,
    output logic                rd_trace,
    output logic                push,
    output logic                push_bit,
    output svm_pkg::walk_e      walk_st
);
    import svm_pkg::*;

    localparam logic [CW-1:0] LAST_COL = CW'(STEPS - 1);

    walk_e         st_q;
    logic [CW-1:0] col_q;
    logic [M-1:0]  cur_q;
    logic          dec_en_q;
    logic [M:0]    ext;
    logic [M-1:0]  prev_s;

    // predecessor: shift the state up, the stored decision enters at bit 0
    assign ext    = {cur_q, rd_vec[cur_q]};
    assign prev_s = ext[M-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= WK_IDLE;
            col_q    <= '0;
            cur_q    <= '0;
            dec_en_q <= 1'b0;
        end else begin
            unique case (st_q)
                WK_IDLE: begin
                    if (start) begin
                        st_q     <= WK_TRACE;
                        col_q    <= LAST_COL;
                        cur_q    <= start_state;
                        dec_en_q <= dec_en;
                    end
                end
                WK_TRACE: begin
                    cur_q <= prev_s;
                    if (col_q == '0) begin
                        if (dec_en_q) begin
                            st_q  <= WK_DECODE;
                            col_q <= LAST_COL;
                        end else begin
                            st_q <= WK_IDLE;
                        end
                    end else begin
                        col_q <= col_q - CW'(1);
                    end
                end
                WK_DECODE: begin
                    if (start) begin
                        st_q     <= WK_TRACE;
                        col_q    <= LAST_COL;
                        cur_q    <= start_state;
                        dec_en_q <= dec_en;
                    end else begin
                        cur_q <= prev_s;
                        if (col_q == '0) begin
                            st_q <= WK_IDLE;
                        end else begin
                            col_q <= col_q - CW'(1);
                        end
                    end
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_col   = col_q;
        rd_trace = (st_q == WK_TRACE);
        push     = (st_q == WK_DECODE);
        push_bit = cur_q[M-1];
        walk_st  = st_q;
    end

endmodule

// File: rtl/svm_lifo.sv
module svm_lifo #(
    parameter int STEPS = 15,
    parameter int PW    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_bit,
    input  logic pop,
    input  logic swap,
    output logic pop_bit
);
    logic [STEPS-1:0] stk [2];
    logic             side_q;
    logic             pop_side;
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [PW-1:0]    rd_idx;

    assign pop_side = ~side_q;
    assign rd_idx   = rd_ptr - PW'(1);

    always_ff @(posedge clk) begin
        if (push && (wr_ptr < PW'(STEPS))) begin
            stk[side_q][wr_ptr] <= push_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_q <= 1'b0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (swap) begin
            side_q <= ~side_q;
            rd_ptr <= wr_ptr + PW'(push);
            wr_ptr <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + PW'(1);
            end
            if (pop && (rd_ptr != '0)) begin
                rd_ptr <= rd_idx;
            end
        end
    end

    assign pop_bit = (rd_ptr != '0) ? stk[pop_side][rd_idx] : 1'b0;

endmodule

// File: rtl/trellis_survivor_mem.sv
module trellis_survivor_mem #(
    parameter int K       = 3,
    parameter int TB_MULT = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dec_valid,
    input  logic [(1<<(K-1))-1:0] dec_vec,
    input  logic [K-2:0]         best_state,
    output logic                 bit_valid,
    output logic                 bit_out
);
    import svm_pkg::*;

    localparam int M     = K - 1;
    localparam int NS    = 1 << M;
    localparam int STEPS = TB_MULT * K;
    localparam int CW    = $clog2(STEPS);
    localparam int PW    = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST_COL = CW'(STEPS - 1);

    logic [CW-1:0] wcol_q;
    logic [1:0]    wr_b, tr_b, dc_b;
    logic [1:0]    rot_cnt;
    logic          wrap;
    logic          pop;
    logic          bit_q, bv_q;

    logic [CW-1:0] rd_col;
    logic          rd_trace;
    logic [1:0]    rd_bank;
    logic [NS-1:0] rd_vec;
    logic          push, push_bit, pop_bit;
    walk_e         walk_st;

    assign wrap    = dec_valid && (wcol_q == LAST_COL);
    assign pop     = dec_valid && (rot_cnt == 2'd3);
    assign rd_bank = rd_trace ? tr_b : dc_b;

    // column pointer, bank roles and warm-up count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcol_q  <= '0;
            wr_b    <= 2'd0;
            tr_b    <= 2'd1;
            dc_b    <= 2'd2;
            rot_cnt <= 2'd0;
        end else if (dec_valid) begin
            if (wrap) begin
                wcol_q <= '0;
                tr_b   <= wr_b;
                dc_b   <= tr_b;
                wr_b   <= dc_b;
                if (rot_cnt != 2'd3) begin
                    rot_cnt <= rot_cnt + 2'd1;
                end
            end else begin
                wcol_q <= wcol_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bv_q  <= 1'b0;
            bit_q <= 1'b0;
        end else begin
            bv_q <= pop;
            if (pop) begin
                bit_q <= pop_bit;
            end
        end
    end

    assign bit_valid = bv_q;
    assign bit_out   = bit_q;

    svm_banks #(.NS(NS), .STEPS(STEPS), .CW(CW)) u_banks (
        .clk     (clk),
        .wr_en   (dec_valid),
        .wr_bank (wr_b),
        .wr_col  (wcol_q),
        .wr_vec  (dec_vec),
        .rd_bank (rd_bank),
        .rd_col  (rd_col),
        .rd_vec  (rd_vec)
    );

    svm_walker #(.M(M), .STEPS(STEPS), .CW(CW)) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (wrap),
        .dec_en      (rot_cnt != 2'd0),
        .start_state (best_state),
        .rd_vec      (rd_vec),
        .rd_col      (rd_col),
        .rd_trace    (rd_trace),
        .push        (push),
        .push_bit    (push_bit),
        .walk_st     (walk_st)
    );

    svm_lifo #(.STEPS(STEPS), .PW(PW)) u_lifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_bit (push_bit),
        .pop      (pop),
        .swap     (wrap),
        .pop_bit  (pop_bit)
    );

endmodule

// File: rtl/svm_chk.sv
module svm_chk #(
    parameter int STEPS = 15,
    parameter int CW    = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           dec_valid,
    input logic           bit_valid,
    input logic [CW-1:0]  wcol,
    input logic [1:0]     wr_b,
    input logic [1:0]     tr_b,
    input logic [1:0]     dc_b,
    input logic [1:0]     rot_cnt,
    input svm_pkg::walk_e walk_st,
    input logic [CW-1:0]  walk_col
);
    import svm_pkg::*;

    localparam logic [CW-1:0] LAST_COL = CW'(STEPS - 1);

    p_no_early_output_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (rot_cnt == 2'd3));

    p_col_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (wcol != LAST_COL)) |=> (wcol == $past(wcol) + CW'(1)));

    p_col_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (wcol == LAST_COL)) |=> (wcol == '0));

    p_role_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (wcol == LAST_COL)) |=>
            ((tr_b == $past(wr_b)) && (dc_b == $past(tr_b)) && (wr_b == $past(dc_b))));

    p_walker_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (wcol == LAST_COL)) |->
            ((walk_st == WK_IDLE) || ((walk_st == WK_DECODE) && (walk_col == '0))));

    p_input_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_valid_needs_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(dec_valid));

endmodule

bind trellis_survivor_mem svm_chk #(.STEPS(STEPS), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .bit_valid (bit_valid),
    .wcol      (wcol_q),
    .wr_b      (wr_b),
    .tr_b      (tr_b),
    .dc_b      (dc_b),
    .rot_cnt   (rot_cnt),
    .walk_st   (walk_st),
    .walk_col  (rd_col)
);

// File: tb/tb_trellis_survivor_mem.sv
module tb_trellis_survivor_mem;

    localparam int K   = 3;
    localparam int M   = K - 1;
    localparam int NS  = 1 << M;
    localparam int LAT = 45;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_valid = 1'b0;
    logic [NS-1:0] dec_vec = '0;
    logic [M-1:0]  best_state = '0;
    logic          bit_valid;
    logic          bit_out;

    int            checks = 0;
    int            errors = 0;
    logic [M-1:0]  enc_s;
    int            idx;
    logic          ubuf [256];
    logic [15:0]   lfsr = 16'hACE1;

    always #5 clk = ~clk;

    trellis_survivor_mem #(.K(K)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_valid  (dec_valid),
        .dec_vec    (dec_vec),
        .best_state (best_state),
        .bit_valid  (bit_valid),
        .bit_out    (bit_out)
    );

    task automatic check_val(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (input %0d)", req, act, exp, idx);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        dec_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_val("R1 reset", bit_valid, 1'b0);
        rst_n = 1'b1;
        enc_s = '0;
        idx   = 0;
    endtask

    // one trellis step of an ideal encoder; off-path decisions are noise
    task automatic send_step(input logic u, input int gap);
        logic [M-1:0]  ns;
        logic [NS-1:0] v;
        ns = {u, enc_s[M-1:1]};
        step_lfsr();
        v     = lfsr[NS-1:0];
        v[ns] = enc_s[0];
        @(negedge clk);
        dec_valid  = 1'b1;
        dec_vec    = v;
        best_state = ns;
        ubuf[idx % 256] = u;
        @(negedge clk);
        dec_valid = 1'b0;
        if (idx >= LAT) begin
            check_val("R7 valid", bit_valid, 1'b1);
            check_val("R2 R3 R4 R5 R6 R7 bit", bit_out, ubuf[(idx - LAT) % 256]);
        end else begin
            check_val("R1 warm-up", bit_valid, 1'b0);
        end
        enc_s = ns;
        idx++;
        for (int g = 1; g < gap; g++) begin
            @(negedge clk);
            check_val("R9 idle", bit_valid, 1'b0);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check_val("R1 after release", bit_valid, 1'b0);
    endtask

    task automatic t_pattern(input int kind, input int n, input int gap);
        logic u;
        do_reset();
        for (int i = 0; i < n; i++) begin
            case (kind)
                0:       u = 1'b0;
                1:       u = 1'b1;
                2:       u = i[0];
                default: begin step_lfsr(); u = lfsr[15]; end
            endcase
            send_step(u, gap);
        end
    endtask

    task automatic t_gap_mix();
        do_reset();
        for (int i = 0; i < 150; i++) begin
            step_lfsr();
            send_step(lfsr[7], 1 + (i % 4));
        end
    endtask

    task automatic t_reset_midstream();
        do_reset();
        for (int i = 0; i < 70; i++) begin
            step_lfsr();
            send_step(lfsr[3], 1);
        end
        do_reset();
        for (int i = 0; i < 75; i++) begin
            step_lfsr();
            send_step(lfsr[5], 2);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        enc_s = '0;
        idx   = 0;
        t_reset_state();
        t_pattern(0, 80, 1);
        t_pattern(1, 80, 1);
        t_pattern(2, 90, 1);
        t_pattern(3, 200, 1);
        t_pattern(3, 100, 3);
        t_gap_mix();
        t_reset_midstream();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule